// File: doc/BRIEF.md
# Prefetch Read Retry Flush Controller

This controller sits beside the read FIFO of a bus target. When a read is cut off by a disconnect while prefetched words are still in the FIFO, it keeps an ownership record: the address and the initiator tag of the interrupted read. It then decides what each later access gets: service from the FIFO, a retry, a one-cycle flush of the FIFO, or nothing at all. The FIFO storage is not part of this block.

A mode bit is read from a boot-time configuration byte while reset is held. In lock mode (bit value 0), the data stays reserved for its owner. Every other access is retried until the owner comes back. If the owner never returns, the path stays blocked for good. In flush mode (bit value 1), a read to a different address discards the data and then goes ahead as a normal read. A read to the held address from the owner is served from the FIFO. When no data is held, the block does nothing.

Every decision is a registered pulse. It appears in the cycle after the one in which the access start is sampled.

Top module: `prfc_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, retry_req, flush_pulse and serve_fifo are low and no ownership record exists.
- R2: With no ownership record held, no access of any kind, read or write, raises retry_req, flush_pulse or serve_fifo.
- R3: The mode is boot_cfg bit 1, sampled while rst is high. Later changes of boot_cfg have no effect until the next reset. No other bit of boot_cfg matters. Value 0 selects lock mode and value 1 selects flush mode.
- R4: A disconnect while fifo_empty is low, with no record held, creates a record. The record holds the address and tag of the last read that was accepted while no record was held. A disconnect while fifo_empty is high creates no record.
- R5: In lock mode with a record held, every access that is not a hit gets a retry. This covers writes, reads with another tag, and reads by the owner to another address. Lock mode never flushes.
- R6: In lock mode the held state is left only by a hit, so an absent owner causes retries with no limit.
- R7: A hit is a read whose address and tag both equal the record. In either mode a hit raises serve_fifo.
- R8: After a hit, the record is cleared on the first cycle in which fifo_empty is high. A disconnect before that cycle puts the record back into the held state.
- R9: In flush mode, a read to another address raises flush_pulse for one cycle. The record is cleared on the same edge. That read is not retried and becomes the candidate for a new record.
- R10: In flush mode with a record held, writes pass with no response and leave the record intact. A read to the held address with a different tag is retried.
- R11: Each response is a one-cycle pulse in the cycle after txn_start is sampled. At most one of the three outputs is high, and no output rises without an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; boot_cfg is sampled while it is high |
| boot_cfg | input | 8 | Boot-time configuration byte; bit 1 selects the mode |
| txn_start | input | 1 | One-cycle strobe marking the start of an access |
| txn_addr | input | ADDR_W | Address of the access |
| txn_tag | input | TAG_W | Identity of the initiator |
| txn_is_read | input | 1 | 1 for a read, 0 for a write |
| disc | input | 1 | One-cycle strobe: the current read was disconnected |
| fifo_empty | input | 1 | The read FIFO holds no data |
| retry_req | output | 1 | Pulse: answer this access with a retry |
| flush_pulse | output | 1 | Pulse: discard the FIFO contents |
| serve_fifo | output | 1 | Pulse: serve this read from the FIFO |

## Verification
The bench first checks that an idle controller never retries or flushes, writes included. A design that is not transparent would stall unrelated traffic. It then checks that a disconnect with an empty FIFO creates no record, which catches a design that locks the path for nothing.

In lock mode, the bench sends a long run of foreign accesses, plus owner accesses to other addresses. Each must be retried, and only the exact hit may be served. This catches a design that compares the address alone, or the tag alone, or one that gives up the lock. The bench also disconnects the owner again during a drain. A design that dropped the record at that point would serve a stranger.

In flush mode, the bench changes boot_cfg after reset and uses a byte with every other bit set. Both would expose a design that reads the mode live or from the wrong bit. It also checks that the flushing read can become the new owner. The record must be gone on the very next access, which catches a late clear or a flush pulse that lasts two cycles.

// File: rtl/prfc_pkg.sv
package prfc_pkg;

    localparam int CFG_W    = 8;
    localparam int MODE_POS = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HELD  = 2'd1,
        ST_DRAIN = 2'd2
    } own_state_e;

    typedef enum logic [1:0] {
        ACT_PASS  = 2'd0,
        ACT_SERVE = 2'd1,
        ACT_RETRY = 2'd2,
        ACT_FLUSH = 2'd3
    } act_e;

    // Response to an access that arrives while a record is held.
    function automatic act_e pick_action(
        input logic flush_mode,
        input logic is_read,
        input logic addr_eq,
        input logic tag_eq
    );
        act_e a;
        if (!flush_mode) begin
            a = (is_read && addr_eq && tag_eq) ? ACT_SERVE : ACT_RETRY;
        end else if (!is_read) begin
            a = ACT_PASS;
        end else if (!addr_eq) begin
            a = ACT_FLUSH;
        end else if (tag_eq) begin
            a = ACT_SERVE;
        end else begin
            a = ACT_RETRY;
        end
        return a;
    endfunction

endpackage

// File: rtl/prfc_mode_latch.sv
module prfc_mode_latch #(
    parameter int CFG_W    = prfc_pkg::CFG_W,
    parameter int MODE_POS = prfc_pkg::MODE_POS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] boot_cfg,
    output logic             mode_q
);
    // The boot byte is followed only while reset is asserted.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= boot_cfg[MODE_POS];
        end
    end
endmodule

// File: rtl/prfc_owner_rec.sv
module prfc_owner_rec #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic              commit,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              addr_eq,
    output logic              tag_eq
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [TAG_W-1:0]  tag;
    } rec_t;

    rec_t cand_q;
    rec_t held_q;

    // The candidate follows accepted reads. On a disconnect it is copied into the held record.
    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q <= '0;
            held_q <= '0;
        end else begin
            if (cap_en) begin
                cand_q.addr <= in_addr;
                cand_q.tag  <= in_tag;
            end
            if (commit) begin
                held_q <= cand_q;
            end
        end
    end

    assign addr_eq = (in_addr == held_q.addr);
    assign tag_eq  = (in_tag  == held_q.tag);
endmodule

// File: rtl/prfc_fsm.sv
module prfc_fsm
    import prfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       txn_start,
    input  logic       txn_is_read,
    input  logic       disc,
    input  logic       fifo_empty,
    input  logic       flush_mode,
    input  logic       addr_eq,
    input  logic       tag_eq,
    output own_state_e st_q,
    output logic       cap_en,
    output logic       commit,
    output logic       retry_q,
    output logic       flush_q,
    output logic       serve_q
);
    act_e       act;
    own_state_e st_d;

    always_comb begin
        act = ACT_PASS;
        if (st_q == ST_HELD && txn_start) begin
            act = pick_action(flush_mode, txn_is_read, addr_eq, tag_eq);
        end
    end

    assign cap_en = txn_start && txn_is_read && ((st_q == ST_IDLE) || (act == ACT_FLUSH));
    assign commit = (st_q == ST_IDLE) && disc && !fifo_empty;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (commit) st_d = ST_HELD;
            ST_HELD: begin
                if (act == ACT_SERVE)      st_d = ST_DRAIN;
                else if (act == ACT_FLUSH) st_d = ST_IDLE;
            end
            ST_DRAIN: begin
                if (fifo_empty) st_d = ST_IDLE;
                else if (disc)  st_d = ST_HELD;
            end
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            retry_q <= 1'b0;
            flush_q <= 1'b0;
            serve_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            retry_q <= (act == ACT_RETRY);
            flush_q <= (act == ACT_FLUSH);
            serve_q <= (act == ACT_SERVE);
        end
    end
endmodule

// File: rtl/prfc_ctrl.sv
module prfc_ctrl
    import prfc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  boot_cfg,
    input  logic              txn_start,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic [TAG_W-1:0]  txn_tag,
    input  logic              txn_is_read,
    input  logic              disc,
    input  logic              fifo_empty,
    output logic              retry_req,
    output logic              flush_pulse,
    output logic              serve_fifo
);
    logic       mode_q;
    logic       addr_eq;
    logic       tag_eq;
    logic       cap_en;
    logic       commit;
    own_state_e st_q;

    prfc_mode_latch #(.CFG_W(CFG_W), .MODE_POS(MODE_POS)) u_mode (
        .clk      (clk),
        .rst      (rst),
        .boot_cfg (boot_cfg),
        .mode_q   (mode_q)
    );

    prfc_owner_rec #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_rec (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .commit  (commit),
        .in_addr (txn_addr),
        .in_tag  (txn_tag),
        .addr_eq (addr_eq),
        .tag_eq  (tag_eq)
    );

    prfc_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .txn_start   (txn_start),
        .txn_is_read (txn_is_read),
        .disc        (disc),
        .fifo_empty  (fifo_empty),
        .flush_mode  (mode_q),
        .addr_eq     (addr_eq),
        .tag_eq      (tag_eq),
        .st_q        (st_q),
        .cap_en      (cap_en),
        .commit      (commit),
        .retry_q     (retry_req),
        .flush_q     (flush_pulse),
        .serve_q     (serve_fifo)
    );
endmodule

// File: rtl/prfc_ctrl_chk.sv
module prfc_ctrl_chk
    import prfc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       txn_start,
    input logic       mode_q,
    input own_state_e st_q,
    input logic       retry_req,
    input logic       flush_pulse,
    input logic       serve_fifo
);
    // R11
    resp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({retry_req, flush_pulse, serve_fifo}));

    // R11
    resp_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        (retry_req || flush_pulse || serve_fifo) |-> $past(txn_start));

    // R2
    quiet_without_record_chk: assert property (@(posedge clk) disable iff (rst)
        (retry_req || flush_pulse) |-> $past(st_q == ST_HELD));

    // R9
    flush_clears_record_chk: assert property (@(posedge clk) disable iff (rst)
        flush_pulse |-> (st_q == ST_IDLE));

    // R9
    flush_single_chk: assert property (@(posedge clk) disable iff (rst)
        flush_pulse |=> !flush_pulse);

    // R5
    lock_no_flush_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_q |-> !flush_pulse);

    // R3
    mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> $stable(mode_q));
endmodule

bind prfc_ctrl prfc_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .txn_start   (txn_start),
    .mode_q      (mode_q),
    .st_q        (st_q),
    .retry_req   (retry_req),
    .flush_pulse (flush_pulse),
    .serve_fifo  (serve_fifo)
);

// File: tb/prfc_ctrl_test.sv
module prfc_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    boot_cfg = 8'h00;
    logic          txn_start = 1'b0;
    logic [AW-1:0] txn_addr = '0;
    logic [TW-1:0] txn_tag = '0;
    logic          txn_is_read = 1'b0;
    logic          disc = 1'b0;
    logic          fifo_empty = 1'b0;
    logic          retry_req, flush_pulse, serve_fifo;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  er;
        logic  ef;
        logic  es;
        string req;
    } exp_t;

    exp_t exp_q[$];

    prfc_ctrl #(.ADDR_W(AW), .TAG_W(TW)) uut (
        .clk         (clk),
        .rst         (rst),
        .boot_cfg    (boot_cfg),
        .txn_start   (txn_start),
        .txn_addr    (txn_addr),
        .txn_tag     (txn_tag),
        .txn_is_read (txn_is_read),
        .disc        (disc),
        .fifo_empty  (fifo_empty),
        .retry_req   (retry_req),
        .flush_pulse (flush_pulse),
        .serve_fifo  (serve_fifo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    localparam logic [AW-1:0] A = 32'h0000_1000;
    localparam logic [AW-1:0] B = 32'h0000_2040;
    localparam logic [AW-1:0] C = 32'h0000_3300;
    localparam logic [AW-1:0] D = 32'h0000_4abc;

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // Driver: queue the expected response, then present one access.
    task automatic access(input logic [AW-1:0] a, input logic [TW-1:0] t, input logic rd,
                          input logic er, input logic ef, input logic es, input string req);
        exp_t e;
        e.er = er; e.ef = ef; e.es = es; e.req = req;
        @(negedge clk);
        exp_q.push_back(e);
        txn_start   = 1'b1;
        txn_addr    = a;
        txn_tag     = t;
        txn_is_read = rd;
        @(negedge clk);
        txn_start   = 1'b0;
    endtask

    task automatic pulse_disc();
        @(negedge clk);
        disc = 1'b1;
        @(negedge clk);
        disc = 1'b0;
    endtask

    task automatic drain_done();
        @(negedge clk);
        fifo_empty = 1'b1;
        @(negedge clk);
        fifo_empty = 1'b0;
    endtask

    task automatic do_reset(input logic [7:0] cfg);
        @(negedge clk);
        rst = 1'b1;
        boot_cfg = cfg;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        boot_cfg = ~cfg;   // R3: must not matter after reset
    endtask

    // Monitor: pair each sampled access with the next queued expectation.
    initial begin
        forever begin
            logic sent;
            exp_t e;
            @(posedge clk);
            sent = txn_start && !rst;
            #(CLK_PERIOD/4);
            if (sent) begin
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R11: access with no expectation, got %b%b%b expected none",
                             retry_req, flush_pulse, serve_fifo);
                end else begin
                    e = exp_q.pop_front();
                    n_cmp++;
                    if (retry_req !== e.er || flush_pulse !== e.ef || serve_fifo !== e.es) begin
                        n_bad++;
                        $display("FAIL %s: retry/flush/serve got %b%b%b expected %b%b%b",
                                 e.req, retry_req, flush_pulse, serve_fifo, e.er, e.ef, e.es);
                    end
                end
            end else if (retry_req || flush_pulse || serve_fifo) begin
                n_bad++;
                $display("FAIL R11: pulse without access, got %b%b%b expected 000",
                         retry_req, flush_pulse, serve_fifo);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // ---- lock mode (boot_cfg bit 1 = 0) ----
        do_reset(8'h00);
        @(negedge clk);
        check("R1", retry_req, 1'b0);
        check("R1", flush_pulse, 1'b0);
        check("R1", serve_fifo, 1'b0);

        // R2: idle controller is transparent
        access(A, 4'd1, 1'b1, 0, 0, 0, "R2");
        access(A, 4'd2, 1'b0, 0, 0, 0, "R2");
        access(B, 4'd3, 1'b1, 0, 0, 0, "R2");

        // R4: disconnect with empty FIFO makes no record
        fifo_empty = 1'b1;
        access(C, 4'd1, 1'b1, 0, 0, 0, "R4");
        pulse_disc();
        fifo_empty = 1'b0;
        access(D, 4'd2, 1'b1, 0, 0, 0, "R4");

        // R4/R5: owner A/1 holds the data
        access(A, 4'd1, 1'b1, 0, 0, 0, "R4");
        pulse_disc();
        access(B, 4'd2, 1'b1, 1, 0, 0, "R5");
        access(A, 4'd2, 1'b1, 1, 0, 0, "R5");
        access(A, 4'd2, 1'b0, 1, 0, 0, "R5");
        access(B, 4'd1, 1'b1, 1, 0, 0, "R5");
        access(A, 4'd1, 1'b0, 1, 0, 0, "R5");
        for (int i = 0; i < 8; i++) begin
            access(C + AW'(i), 4'(i + 2), 1'b1, 1, 0, 0, "R6");
        end
        access(A, 4'd1, 1'b1, 0, 0, 1, "R7");
        // R8: disconnect again during drain puts the lock back
        pulse_disc();
        access(B, 4'd2, 1'b1, 1, 0, 0, "R8");
        access(A, 4'd1, 1'b1, 0, 0, 1, "R7");
        drain_done();
        access(B, 4'd2, 1'b1, 0, 0, 0, "R8");
        access(A, 4'd1, 1'b1, 0, 0, 0, "R8");

        // ---- flush mode (boot_cfg bit 1 = 1), boot_cfg flipped after reset ----
        do_reset(8'h02);
        access(A, 4'd1, 1'b1, 0, 0, 0, "R4");
        pulse_disc();
        access(C, 4'd3, 1'b0, 0, 0, 0, "R10");
        access(A, 4'd2, 1'b1, 1, 0, 0, "R10");
        access(A, 4'd1, 1'b1, 0, 0, 1, "R7");
        drain_done();

        access(A, 4'd1, 1'b1, 0, 0, 0, "R2");
        pulse_disc();
        access(B, 4'd2, 1'b1, 0, 1, 0, "R3");
        pulse_disc();                       // R9: flushing read becomes owner
        access(A, 4'd1, 1'b1, 0, 1, 0, "R9");
        pulse_disc();
        access(A, 4'd1, 1'b1, 0, 0, 1, "R9");
        drain_done();
        access(C, 4'd1, 1'b1, 0, 0, 0, "R2");
        pulse_disc();
        access(D, 4'd1, 1'b1, 0, 1, 0, "R9");
        access(C, 4'd1, 1'b1, 0, 0, 0, "R9");

        // ---- R3: only bit 1 counts; all other bits set selects lock mode ----
        do_reset(8'hFD);
        access(A, 4'd1, 1'b1, 0, 0, 0, "R3");
        pulse_disc();
        access(B, 4'd2, 1'b1, 1, 0, 0, "R3");
        access(B, 4'd1, 1'b1, 1, 0, 0, "R3");
        access(A, 4'd1, 1'b1, 0, 0, 1, "R7");
        drain_done();

        repeat (3) @(negedge clk);
        check("R11", retry_req | flush_pulse | serve_fifo, 1'b0);
        check("R11", exp_q.size() == 0, 1'b1);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule